// File: doc/BRIEF.md
# Sequenced-Service Watchdog Timer

This block is a watchdog timer that sits on a simple 16-bit register bus. Software writes a timeout into the control register and sets the enable bit. From then on the block counts down once per half-second tick, and software must reload it by writing a two-word key sequence to the service register. If the count runs out, the block raises a one-cycle system reset pulse. It also sets a sticky flag that tells software after the restart that the last reset came from the watchdog. The half-second tick comes from an external prescaler as a single-cycle enable. Once the timer is running, nothing short of a reset can stop it.

Byte offsets: control at 0x0, service at 0x2, reset status at 0x4. There are two reset inputs. `rst_n` is the system reset, which the watchdog pulse would normally drive, and it clears everything except the status flag. `por_n` is the power-on reset, and it clears everything including the status flag.

The design has three state machines:
- **Enable lock**: `EN_OFF` goes to `EN_ON` on a control write with bit 2 set. `EN_ON` has no exit.
- **Key checker**: `SVC_IDLE` goes to `SVC_ARMED` on a service write of 0x5555. In `SVC_ARMED`, a write of 0x5555 stays in `SVC_ARMED`. A write of 0xAAAA is accepted as a reload and returns to `SVC_IDLE`. Any other service write returns to `SVC_IDLE`.
- **Countdown**: `CNT_OFF` goes to `CNT_RUN` once enabled, loading the count. `CNT_RUN` goes to `CNT_FIRE` on expiry, unless reset is suppressed. `CNT_FIRE` returns to `CNT_RUN` after one cycle, reloading the count.

Top module: `seq_watchdog`

## Requirements
- R1: After power-on reset every register reads 0x0000 and `wdog_rst` is low.
- R2: Control register layout: bits 15:8 hold the timeout field N, bit 3 is reset-suppress, bit 2 is enable. The other bits read as 0.
- R3: The enable bit is sticky. A control write with bit 2 clear leaves it set and leaves the countdown running.
- R4: Once enabled, the counter is loaded with N on the next cycle. `wdog_rst` goes high for exactly one cycle after the (N+1)-th tick following the load, which is N+1 half-seconds.
- R5: Writing 0x5555 and then 0xAAAA to the service register reloads the counter from the timeout field. A reload in the same cycle as a tick takes priority over the tick.
- R6: 0xAAAA reloads only when the previous service write was 0x5555. Any other value in between clears the partial sequence. A repeated 0x5555 keeps the sequence armed.
- R7: Rewriting the timeout field while the timer runs does not change the current count. The new value is used from the next reload onward, whether that reload comes from a service sequence or an expiry.
- R8: Status bit 1 reads 1 after a timeout reset pulse. It survives `rst_n` and is cleared only by `por_n`. Bus writes to it have no effect.
- R9: With reset-suppress set, an expiry produces no pulse and does not set the status bit. The counter reloads and keeps running.
- R10: The service register reads 0. Writes and reads at unmapped offsets have no effect and read 0.
- R11: While not enabled, ticks have no effect and no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, clears the status flag as well |
| rst_n | input | 1 | System reset, active low, keeps the status flag |
| tick_en | input | 1 | Half-second tick enable from the prescaler |
| bus_addr | input | 3 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| wdog_rst | output | 1 | One-cycle system reset pulse on timeout |

## Verification
Directed runs use a small timeout field so that the exact tick on which the pulse fires can be counted. These runs separate a correct N+1 expiry from off-by-one counts, and a real reload from a merely armed sequence. Sequences with a foreign word between the keys, and with a doubled first key, separate a strict two-word checker from one that accepts the keys in any order. A field change mid-count, followed by a natural expiry, shows whether the field is used only at reload. Random traffic mixes ticks, service words, control and unmapped writes, and is compared cycle by cycle with a bench reference model. This catches priority mistakes between a tick and a reload landing in the same cycle.

// File: rtl/seq_wdt_pkg.sv
package seq_wdt_pkg;
    typedef enum logic [1:0] {
        CNT_OFF  = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_FIRE = 2'd2
    } cnt_state_e;

    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_e;

    typedef enum logic {
        EN_OFF = 1'b0,
        EN_ON  = 1'b1
    } en_state_e;
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
    import seq_wdt_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int FIELD_W   = 8,
    parameter int FIELD_LSB = 8,
    parameter int NORST_BIT = 3,
    parameter int EN_BIT    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctrl,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FIELD_W-1:0] tmo_field,
    output logic               no_rst,
    output logic               en
);
    en_state_e en_state, en_next;

    // enable lock: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_state <= EN_OFF;
        else        en_state <= en_next;
    end

    always_comb begin
        en_next = en_state;
        unique case (en_state)
            EN_OFF: if (wr_ctrl && wdata[EN_BIT]) en_next = EN_ON;
            EN_ON:  en_next = EN_ON;
            default: en_next = EN_OFF;
        endcase
    end

    // timeout field and reset-suppress are freely writable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_field <= '0;
            no_rst    <= 1'b0;
        end else if (wr_ctrl) begin
            tmo_field <= wdata[FIELD_LSB +: FIELD_W];
            no_rst    <= wdata[NORST_BIT];
        end
    end

    always_comb en = (en_state == EN_ON);

    // R3
    en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);
endmodule

// File: rtl/wdt_svc_seq.sv
module wdt_svc_seq
    import seq_wdt_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY1 = 16'h5555,
    parameter logic [DATA_W-1:0] KEY2 = 16'hAAAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_svc,
    input  logic [DATA_W-1:0] wdata,
    output logic              reload
);
    svc_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SVC_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (wr_svc) begin
            unique case (state)
                SVC_IDLE:  nxt = (wdata == KEY1) ? SVC_ARMED : SVC_IDLE;
                SVC_ARMED: nxt = (wdata == KEY1) ? SVC_ARMED : SVC_IDLE;
                default:   nxt = SVC_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        reload = 1'b0;
        unique case (state)
            SVC_IDLE:  reload = 1'b0;
            SVC_ARMED: reload = wr_svc && (wdata == KEY2);
            default:   reload = 1'b0;
        endcase
    end

    // R6
    svc_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> state == SVC_IDLE);
    // R6
    svc_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_svc && wdata == KEY1) |=> state == SVC_ARMED);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import seq_wdt_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               reload,
    input  logic               no_rst,
    input  logic [FIELD_W-1:0] field,
    output logic               trip,
    output logic               fire
);
    cnt_state_e state, nxt;
    logic [FIELD_W-1:0] cnt_q;
    logic expire;

    always_comb expire = (state == CNT_RUN) && tick && !reload && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CNT_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CNT_OFF:  if (en) nxt = CNT_RUN;
            CNT_RUN:  if (expire && !no_rst) nxt = CNT_FIRE;
            CNT_FIRE: nxt = CNT_RUN;
            default:  nxt = CNT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state)
                CNT_OFF:  cnt_q <= field;
                CNT_RUN: begin
                    if (reload)             cnt_q <= field;
                    else if (tick) begin
                        if (cnt_q == '0)    cnt_q <= field;
                        else                cnt_q <= cnt_q - 1'b1;
                    end
                end
                CNT_FIRE: cnt_q <= field;
                default:  cnt_q <= field;
            endcase
        end
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        trip = 1'b0;
        unique case (state)
            CNT_OFF:  fire = 1'b0;
            CNT_RUN:  trip = expire && !no_rst;
            CNT_FIRE: fire = 1'b1;
            default:  fire = 1'b0;
        endcase
    end

    // R11
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == CNT_OFF);
    // R5
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_RUN && reload) |=> cnt_q == $past(field));
    // R4
    fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == CNT_FIRE |=> state == CNT_RUN);
endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
    import seq_wdt_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter int              ADDR_W    = 3,
    parameter int              FIELD_W   = 8,
    parameter int              FIELD_LSB = 8,
    parameter int              NORST_BIT = 3,
    parameter int              EN_BIT    = 2,
    parameter int              TOUT_BIT  = 1,
    parameter logic [ADDR_W-1:0] OFF_CTRL = 3'h0,
    parameter logic [ADDR_W-1:0] OFF_SVC  = 3'h2,
    parameter logic [ADDR_W-1:0] OFF_STAT = 3'h4,
    parameter logic [DATA_W-1:0] KEY1     = 16'h5555,
    parameter logic [DATA_W-1:0] KEY2     = 16'hAAAA
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdog_rst
);
    logic               rst_all_n;
    logic               wr_ctrl, wr_svc;
    logic [FIELD_W-1:0] tmo_field;
    logic               no_rst, en, reload, trip, fire;
    logic               tout_q;

    always_comb rst_all_n = rst_n & por_n;
    always_comb wr_ctrl   = bus_wr && (bus_addr == OFF_CTRL);
    always_comb wr_svc    = bus_wr && (bus_addr == OFF_SVC);

    wdt_ctrl_regs #(
        .DATA_W(DATA_W), .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB),
        .NORST_BIT(NORST_BIT), .EN_BIT(EN_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_all_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
        .tmo_field(tmo_field), .no_rst(no_rst), .en(en)
    );

    wdt_svc_seq #(.DATA_W(DATA_W), .KEY1(KEY1), .KEY2(KEY2)) u_svc (
        .clk(clk), .rst_n(rst_all_n), .wr_svc(wr_svc), .wdata(bus_wdata),
        .reload(reload)
    );

    wdt_countdown #(.FIELD_W(FIELD_W)) u_cnt (
        .clk(clk), .rst_n(rst_all_n), .en(en), .tick(tick_en),
        .reload(reload), .no_rst(no_rst), .field(tmo_field),
        .trip(trip), .fire(fire)
    );

    // reset-cause flag lives in the power-on domain only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)    tout_q <= 1'b0;
        else if (trip) tout_q <= 1'b1;
    end

    always_comb wdog_rst = fire;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CTRL: begin
                bus_rdata[FIELD_LSB +: FIELD_W] = tmo_field;
                bus_rdata[NORST_BIT]            = no_rst;
                bus_rdata[EN_BIT]               = en;
            end
            OFF_STAT: bus_rdata[TOUT_BIT] = tout_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R8
    tout_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        tout_q |=> tout_q);
    // R8
    rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
        wdog_rst |-> tout_q);
    // R4
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
        wdog_rst |=> !wdog_rst);
    // R9
    suppress_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
        (no_rst && $stable(no_rst)) |-> !wdog_rst);
endmodule

// File: tb/seq_watchdog_tb_top.sv
`timescale 1ns/1ps
module seq_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdog_rst;

    always #2 clk = ~clk;

    seq_watchdog dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdog_rst(wdog_rst)
    );

    int    checks = 0, errors = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model
    bit       m_en, m_dis, m_run, m_fire, m_arm, m_tout;
    bit [7:0] m_field, m_cnt;

    function automatic logic [15:0] exp_read(logic [2:0] a);
        if (a == 3'h0) return {m_field, 4'b0, m_dis, m_en, 2'b0};
        if (a == 3'h4) return {14'b0, m_tout, 1'b0};
        return 16'h0;
    endfunction

    task automatic check(string rq, logic [15:0] act, logic [15:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic model_clear(bit keep_tout);
        m_en = 0; m_dis = 0; m_run = 0; m_fire = 0; m_arm = 0;
        m_field = 0; m_cnt = 0;
        if (!keep_tout) m_tout = 0;
    endtask

    task automatic model_step(bit wr, bit [2:0] a, bit [15:0] d, bit tk);
        bit rl;
        rl = wr && a == 3'h2 && m_arm && d == 16'hAAAA;
        if (!m_run) begin
            m_cnt = m_field;
            if (m_en) m_run = 1;
        end else if (m_fire) begin
            m_fire = 0; m_cnt = m_field;
        end else if (rl) begin
            m_cnt = m_field;
        end else if (tk) begin
            if (m_cnt == 0) begin
                if (!m_dis) begin m_fire = 1; m_tout = 1; end
                m_cnt = m_field;
            end else m_cnt = m_cnt - 1;
        end
        if (wr && a == 3'h0) begin
            m_field = d[15:8]; m_dis = d[3]; m_en = m_en | d[2];
        end
        if (wr && a == 3'h2) m_arm = (d == 16'h5555);
    endtask

    // one bus cycle; optional explicit pulse check named by requirement
    task automatic cyc(bit wr, bit [2:0] a, bit [15:0] d, bit tk,
                       string rq = "", bit exp_rst = 0);
        @(negedge clk);
        check(tag, {15'b0, wdog_rst}, {15'b0, m_fire}, "wdog_rst(model)");
        if (rq != "") check(rq, {15'b0, wdog_rst}, {15'b0, exp_rst}, "wdog_rst");
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
        #0.5;
        if (!wr) check(tag, bus_rdata, exp_read(a), $sformatf("read@%0h", a));
        model_step(wr, a, d, tk);
    endtask

    task automatic wr(bit [2:0] a, bit [15:0] d); cyc(1, a, d, 0); endtask
    task automatic rd(bit [2:0] a); cyc(0, a, 16'h0, 0); endtask
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(0, 3'h0, 16'h0, 1);
    endtask
    task automatic expect_rst(string rq, bit e); cyc(0, 3'h0, 16'h0, 0, rq, e); endtask

    task automatic do_reset(bit power);
        @(negedge clk);
        bus_wr = 0; tick_en = 0;
        rst_n = 0; if (power) por_n = 0;
        model_clear(!power);
        repeat (2) @(negedge clk);
        rst_n = 1; por_n = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        m_tout = 0;
        do_reset(1);
        // R1: reset values
        tag = "R1";
        rd(3'h0); rd(3'h2); rd(3'h4);
        expect_rst("R1", 0);
        // R2: layout, unused bits read 0
        tag = "R2";
        wr(3'h0, 16'h12F3); rd(3'h0);
        check("R2", bus_rdata, 16'h1200, "ctrl layout");
        wr(3'h0, 16'h1208); rd(3'h0);
        // R11: ticks while disabled do nothing
        tag = "R11";
        ticks(10); expect_rst("R11", 0);
        // R4: field 3 -> pulse after 4th tick
        tag = "R4";
        wr(3'h0, 16'h0304); rd(3'h0);
        ticks(3); expect_rst("R4", 0);
        ticks(1); expect_rst("R4", 1); expect_rst("R4", 0);
        rd(3'h4);
        // R3: enable cannot be cleared
        tag = "R3";
        wr(3'h0, 16'h0300); rd(3'h0);
        check("R3", bus_rdata, 16'h0304, "enable sticky");
        ticks(3); expect_rst("R3", 0);
        ticks(1); expect_rst("R3", 1); expect_rst("R3", 0);
        // R5: proper sequence reloads; reload beats tick
        tag = "R5";
        ticks(2); wr(3'h2, 16'h5555); cyc(1, 3'h2, 16'hAAAA, 1);
        ticks(3); expect_rst("R5", 0);
        ticks(1); expect_rst("R5", 1); expect_rst("R5", 0);
        // R6: foreign word breaks sequence
        tag = "R6";
        ticks(2); wr(3'h2, 16'h5555); wr(3'h2, 16'h1234); wr(3'h2, 16'hAAAA);
        ticks(1); expect_rst("R6", 0);
        ticks(1); expect_rst("R6", 1); expect_rst("R6", 0);
        // R6: doubled first key stays armed
        ticks(2); wr(3'h2, 16'h5555); wr(3'h2, 16'h5555); wr(3'h2, 16'hAAAA);
        ticks(3); expect_rst("R6", 0);
        ticks(1); expect_rst("R6", 1); expect_rst("R6", 0);
        // R7: new field used only at next reload
        tag = "R7";
        wr(3'h0, 16'h0104);
        ticks(3); expect_rst("R7", 0);
        ticks(1); expect_rst("R7", 1); expect_rst("R7", 0);
        ticks(1); expect_rst("R7", 0);
        ticks(1); expect_rst("R7", 1); expect_rst("R7", 0);
        // R10: service reads 0, unmapped writes ignored
        tag = "R10";
        rd(3'h2);
        wr(3'h6, 16'hFFFF); wr(3'h1, 16'h0000); wr(3'h7, 16'h0F0C);
        rd(3'h0); check("R10", bus_rdata, 16'h0104, "ctrl after unmapped writes");
        rd(3'h6); rd(3'h3);
        // R8: status survives system reset, write-protected, cleared by POR
        tag = "R8";
        wr(3'h4, 16'h0000); rd(3'h4);
        check("R8", bus_rdata, 16'h0002, "status after write");
        do_reset(0); rd(3'h4);
        check("R8", bus_rdata, 16'h0002, "status after rst_n");
        rd(3'h0);
        do_reset(1); rd(3'h4);
        check("R8", bus_rdata, 16'h0000, "status after por_n");
        // R9: suppressed expiry
        tag = "R9";
        wr(3'h0, 16'h000C); ticks(3); expect_rst("R9", 0);
        rd(3'h4); check("R9", bus_rdata, 16'h0000, "status suppressed");
        wr(3'h0, 16'h0004); ticks(1); expect_rst("R9", 1);
        // random traffic against the model
        tag = "RND";
        do_reset(1);
        for (int i = 0; i < 4000; i++) begin
            int unsigned op;
            bit tk;
            op = $urandom % 100;
            tk = ($urandom % 2) == 1;
            if (op < 30)      cyc(0, 3'($urandom % 8), 16'h0, tk);
            else if (op < 40) cyc(1, 3'h0, {8'($urandom % 6), 8'($urandom)}, tk);
            else if (op < 60) cyc(1, 3'h2, 16'h5555, tk);
            else if (op < 80) cyc(1, 3'h2, 16'hAAAA, tk);
            else if (op < 88) cyc(1, 3'h2, 16'($urandom), tk);
            else              cyc(1, 3'($urandom % 8) | 3'h1, 16'($urandom), tk);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule